// File: doc/BRIEF.md
# Capacitor-ID Sequence Checker and Word Repacker

The block takes 16-bit front-end words, each of which carries two readout channels and a 2-bit capacitor identifier. Each channel is a 5-bit mantissa with a 2-bit exponent. For every accepted word it emits one 16-bit output word. The output keeps the identifier and both mantissas, and merges the two exponents into one 2-bit field by a bitwise OR. It also inserts two flags. One flag marks a break in the rolling identifier count. The other carries a link-error input that arrives together with the word.

The capacitor identifier is expected to advance by one, modulo four, on every accepted word. The block holds the identifier of the last accepted word and compares each new word against it. If a word is not the successor, that same word is flagged on the output, not the word after it. A word is accepted only when its strobe is high and the link reports a data-carrying mode. Words seen while the link is idle are dropped.

The stored identifier is never cleared when the link goes idle. As a result, the first word after an idle stretch can be flagged even if the stream itself is healthy. Downstream logic is expected to tolerate this.

Top module: `cidchk_top`

## Requirements
- R1: Input fields are CapID at bits 15:14, channel-B exponent at 13:12, channel-B mantissa at 11:7, channel-A exponent at 6:5 and channel-A mantissa at 4:0. The output carries CapID at 15:14, channel-B mantissa at 11:7 and channel-A mantissa at 4:0, all unchanged.
- R2: Output bit 6 is the OR of the two exponents' bit 1, and output bit 5 is the OR of their bit 0.
- R3: Output bit 13 is 1 exactly when the word's CapID is not the previous accepted CapID plus one, modulo 4. The flag sits on that same output word.
- R4: The stored CapID takes the value of every accepted word, including a flagged one. A single jump in the count therefore flags one word, and checking resumes from the new value.
- R5: Output bit 12 equals the `link_err` value sampled in the cycle the word is accepted.
- R6: A word is accepted only when `word_vld` is 1 and `link_mode` is 2'b01 (control) or 2'b10 (data). With 2'b00 (idle) or 2'b11, the word produces no output and leaves the stored CapID unchanged.
- R7: The stored CapID keeps its value through idle periods. The first word after idle is compared against the last word accepted before idle, and can raise a spurious error.
- R8: `out_vld` is 1 for exactly one cycle, one clock after each accepted word. `out_word` holds its value while no word is accepted.
- R9: While `rst` is high, `out_vld` and `out_word` are 0 and the stored CapID becomes 2'b11. A word with CapID 2'b00 is therefore accepted without error right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Front-end word strobe |
| link_mode | input | 2 | 00 idle, 01 control, 10 data, 11 reserved |
| link_err | input | 1 | Link error for the current word |
| fe_word | input | 16 | Front-end word |
| out_vld | output | 1 | Output word strobe |
| out_word | output | 16 | Repacked word with flags |

## Verification
A sequence error and a link error can land on the same output word, and both flags must then be set side by side without disturbing the data fields. The stimulus table provokes this by pairing a repeated CapID with a high `link_err`. Each flag is then compared against a bench model that tracks the previous CapID and samples `link_err` per accepted word. A second collision is a count break coinciding with a link-mode change: the table resumes data after an idle and a reserved-mode word, and the expected error bit is derived from the CapID last accepted before the gap.

// File: rtl/cidchk_pkg.sv
package cidchk_pkg;
  localparam int CID_W  = 2;
  localparam int EXP_W  = 2;
  localparam int MANT_W = 5;
  localparam int WORD_W = CID_W + 2*EXP_W + 2*MANT_W;

  typedef enum logic [1:0] {
    LM_IDLE = 2'b00,
    LM_CTRL = 2'b01,
    LM_DATA = 2'b10,
    LM_RSVD = 2'b11
  } link_mode_e;

  typedef struct packed {
    logic [CID_W-1:0]  cid;
    logic [EXP_W-1:0]  exp_b;
    logic [MANT_W-1:0] mant_b;
    logic [EXP_W-1:0]  exp_a;
    logic [MANT_W-1:0] mant_a;
  } fe_word_t;

  typedef struct packed {
    logic [CID_W-1:0]  cid;
    logic              seq_err;
    logic              lnk_err;
    logic [MANT_W-1:0] mant_b;
    logic [EXP_W-1:0]  exp_or;
    logic [MANT_W-1:0] mant_a;
  } out_word_t;
endpackage

// File: rtl/cidchk_seq.sv
module cidchk_seq #(
  parameter int CID_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CID_W-1:0] cid,
  output logic             seq_err,
  output logic [CID_W-1:0] prev_cid
);
  localparam logic [CID_W-1:0] CID_RST = '1;
  localparam logic [CID_W-1:0] CID_ONE = CID_W'(1);

  logic [CID_W-1:0] next_expected;

  assign next_expected = prev_cid + CID_ONE;
  assign seq_err       = take && (cid != next_expected);

  // stored identifier follows every accepted word, errored or not
  always_ff @(posedge clk) begin
    if (rst)       prev_cid <= CID_RST;
    else if (take) prev_cid <= cid;
  end

  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (rst)
    take |=> prev_cid == $past(cid)); // R4
  AST_PREV_KEPT: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(prev_cid)); // R7
endmodule

// File: rtl/cidchk_merge.sv
module cidchk_merge
  import cidchk_pkg::*;
(
  input  fe_word_t  fe,
  input  logic      seq_err,
  input  logic      lnk_err,
  output out_word_t packed_w
);
  logic [EXP_W-1:0] exp_or;

  for (genvar g = 0; g < EXP_W; g++) begin : g_exp
    assign exp_or[g] = fe.exp_b[g] | fe.exp_a[g];
  end

  always_comb begin
    packed_w.cid     = fe.cid;
    packed_w.seq_err = seq_err;
    packed_w.lnk_err = lnk_err;
    packed_w.mant_b  = fe.mant_b;
    packed_w.exp_or  = exp_or;
    packed_w.mant_a  = fe.mant_a;
  end
endmodule

// File: rtl/cidchk_top.sv
module cidchk_top
  import cidchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [1:0]        link_mode,
  input  logic              link_err,
  input  logic [WORD_W-1:0] fe_word,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_word
);
  fe_word_t         fe;
  out_word_t        packed_w;
  logic             take;
  logic             seq_err;
  logic [CID_W-1:0] prev_cid;

  assign fe   = fe_word_t'(fe_word);
  assign take = word_vld &&
                (link_mode == LM_CTRL || link_mode == LM_DATA);

  cidchk_seq #(.CID_W(CID_W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .cid      (fe.cid),
    .seq_err  (seq_err),
    .prev_cid (prev_cid)
  );

  cidchk_merge merge_i (
    .fe       (fe),
    .seq_err  (seq_err),
    .lnk_err  (link_err),
    .packed_w (packed_w)
  );

  // all fields and flags leave through one register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= take;
      if (take) out_word <= WORD_W'(packed_w);
    end
  end

  AST_CID_PASS: assert property (@(posedge clk) disable iff (rst)
    take |=> out_word[15:14] == $past(fe_word[15:14])
             && out_word[11:7] == $past(fe_word[11:7])
             && out_word[4:0] == $past(fe_word[4:0])); // R1
  AST_EXP_MERGE: assert property (@(posedge clk) disable iff (rst)
    take |=> out_word[6:5] == ($past(fe_word[13:12]) | $past(fe_word[6:5]))); // R2
  AST_SEQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    take |=> out_word[13] == ($past(fe_word[15:14]) != $past(prev_cid + 2'd1))); // R3
  AST_LERR_SLOT: assert property (@(posedge clk) disable iff (rst)
    take |=> out_word[12] == $past(link_err)); // R5
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
    (word_vld && link_mode == LM_IDLE) |=> !out_vld); // R6
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(out_word)); // R8
endmodule

// File: tb/cidchk_tb.sv
module cidchk_top_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 16;
  // {link_mode[1:0], word_vld, link_err, fe_word[15:0]}
  localparam logic [19:0] VEC [NV] = '{
    20'hA_1234, 20'hA_5A5A, 20'hB_9FFF, 20'hA_E041,
    20'hA_3021, 20'h8_FFFF, 20'hA_8C63, 20'hA_C000,
    20'hB_D555, 20'h2_4AAA, 20'h6_0F0F, 20'hE_2222,
    20'h6_6B6B, 20'hA_AAAA, 20'hA_0000, 20'hA_7FFF
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        word_vld;
  logic [1:0]  link_mode;
  logic        link_err;
  logic [15:0] fe_word;
  logic        out_vld;
  logic [15:0] out_word;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0]  m_prev;
  logic [15:0] m_word;
  logic        m_vld;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  cidchk_top dut_i (
    .clk(clk), .rst(rst), .word_vld(word_vld), .link_mode(link_mode),
    .link_err(link_err), .fe_word(fe_word), .out_vld(out_vld),
    .out_word(out_word)
  );

  // model built from the requirements
  task automatic model_step(input logic [1:0] md, input logic v,
                            input logic le, input logic [15:0] w);
    logic acc;
    logic err;
    acc = v && (md == 2'b01 || md == 2'b10);
    m_vld = acc;
    if (acc) begin
      err = (w[15:14] != m_prev + 2'd1);
      m_word = {w[15:14], err, le, w[11:7], w[13] | w[6], w[12] | w[5], w[4:0]};
      m_prev = w[15:14];
    end
  endtask

  task automatic check(input string req);
    n_chk++;
    if (out_vld !== m_vld || out_word !== m_word) begin
      n_bad++;
      $display("FAIL %s: got vld=%b word=%h, expected vld=%b word=%h",
               req, out_vld, out_word, m_vld, m_word);
    end
  endtask

  // drive at a falling edge, check at the next one
  task automatic apply(input logic [1:0] md, input logic v, input logic le,
                       input logic [15:0] w, input string req);
    link_mode = md; word_vld = v; link_err = le; fe_word = w;
    model_step(md, v, le, w);
    @(negedge clk);
    check(req);
  endtask

  task automatic do_reset();
    rst = 1'b1; word_vld = 1'b0; link_mode = 2'b00; link_err = 1'b0; fe_word = '0;
    @(negedge clk); @(negedge clk);
    m_prev = 2'b11; m_word = '0; m_vld = 1'b0;
    check("R9 reset state");
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // table walk: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][19:18], VEC[i][17], VEC[i][16], VEC[i][15:0],
            "R1/R2/R3/R4/R5/R6/R8 table");
    end
    // R5 with R3: both flags on one word (prev is 1, repeat 1)
    apply(2'b10, 1'b1, 1'b1, 16'h5555, "R3 R5 both flags");
    // R7: idle gap, stream resumes at cid 3 while stored is 1 -> spurious flag
    apply(2'b00, 1'b0, 1'b0, 16'h0000, "R6 idle");
    apply(2'b00, 1'b1, 1'b0, 16'h8888, "R6 idle word dropped");
    apply(2'b10, 1'b1, 1'b0, 16'hC3C3, "R7 first word after idle");
    apply(2'b10, 1'b1, 1'b0, 16'h0101, "R4 resync after flag");
    // R8 hold over two empty cycles
    apply(2'b10, 1'b0, 1'b1, 16'hFFFF, "R8 hold");
    apply(2'b01, 1'b0, 1'b0, 16'h1111, "R8 hold");
    // R9: reset mid-stream, then cid 0 passes clean
    do_reset();
    apply(2'b10, 1'b1, 1'b0, 16'h0000, "R9 cid 0 after reset");
    apply(2'b10, 1'b1, 1'b0, 16'h4000, "R3 step after reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P*5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule